// File: doc/BRIEF.md
# Multithreaded Retire Slot Thread Selector

This block decides which hardware thread may retire the instruction at the head of its reorder buffer in a commit slot. For each thread it takes a thread status, a buffer-not-empty flag, a head-ready flag and the sequence number of the head instruction. From these it returns one thread id and a valid flag. The result is combinational in the inputs, so the commit logic can present updated thread state and ask again for each slot in a cycle. The caller raises `grant_take` when it actually retires the granted instruction.

A two-bit `policy` input selects the rule at run time. Fair rotation keeps an ordered list of threads, and each consumed grant moves the granted thread to the tail of that list. Oldest-first picks the eligible thread whose head sequence number is smallest. A third, aggressive code reuses the oldest-first rule, applied again for every slot. When the block is built for a single thread, all of this is replaced by a status-only bypass.

Top module: `smt_commit_arb`

## Requirements
- R1: A thread is eligible only when its status code is 0 (idle), 1 (running) or 2 (fetch trap pending), its `rob_nonempty` bit is 1 and its `head_ready` bit is 1. Status codes 3 (trap pending) and 4 (squashing) are never eligible. `thr_state` holds 3 bits per thread, with thread t at bits [3t+2:3t].
- R2: When no thread is eligible, `grant_valid` is 0 and `grant_id` is 0.
- R3: With `policy` = 0 (rotation), the grant goes to the first eligible thread in the current order list.
- R4: Under rotation, a clock edge with `grant_take` = 1 and a valid grant moves the granted thread to the tail of the order list. The other threads keep their relative order.
- R5: The order list does not change on any edge without a consumed rotation grant. This covers `grant_take` = 0, no valid grant, and any `policy` other than 0.
- R6: After reset the order list is 0, 1, ..., N-1, with thread 0 first.
- R7: With `policy` = 1 (oldest-first), the grant goes to the eligible thread with the smallest `head_seq`, compared as unsigned. `head_seq` holds SEQ_W bits per thread, with thread t at bits [SEQ_W*(t+1)-1:SEQ_W*t].
- R8: Under oldest-first selection, equal sequence numbers resolve to the lower thread id.
- R9: `policy` = 2 (aggressive) and the unused code 3 both select exactly as oldest-first does.
- R10: With one thread, `grant_valid` is 1 exactly when its status code is 0, 1 or 2. This holds whatever the policy, `rob_nonempty` or `head_ready`, and `grant_id` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy | input | 2 | 0 rotation, 1 oldest-first, 2 aggressive, 3 as oldest-first |
| thr_state | input | 3*NUM_THR | Per-thread status codes |
| rob_nonempty | input | NUM_THR | Per-thread buffer holds an instruction |
| head_ready | input | NUM_THR | Per-thread head instruction can retire |
| head_seq | input | SEQ_W*NUM_THR | Per-thread head sequence number |
| grant_take | input | 1 | Current grant is consumed at this edge |
| grant_valid | output | 1 | A thread was selected |
| grant_id | output | ID_W | Selected thread id |

## Verification
The hardest state to reach from the ports is a rotation order that has been shuffled by consumed grants and has then sat through stalls and through cycles spent under other policies. An order left untouched there looks the same as one rebuilt from reset. The stimulus switches policy every 40 cycles and withholds the take on every fourth slot. It also spreads eligibility so that different threads win. A bench-side copy of the order list is updated only on consumed rotation grants, so any spurious reordering shows up as a wrong grant later on.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_RUNNING = 3'd1,
        TS_FTRAP   = 3'd2,
        TS_TRAP    = 3'd3,
        TS_SQUASH  = 3'd4
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_ROTATE = 2'd0,
        POL_OLDEST = 2'd1,
        POL_AGGR   = 2'd2
    } policy_e;

    function automatic logic state_can_retire(input logic [2:0] st);
        return (st == TS_IDLE) || (st == TS_RUNNING) || (st == TS_FTRAP);
    endfunction
endpackage

// File: rtl/arb_elig.sv
module arb_elig #(
    parameter int NUM_THR = 4
) (
    input  logic [3*NUM_THR-1:0] thr_state,
    input  logic [NUM_THR-1:0]   rob_nonempty,
    input  logic [NUM_THR-1:0]   head_ready,
    output logic [NUM_THR-1:0]   elig
);
    import smt_arb_pkg::*;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign elig[t] = state_can_retire(thr_state[3*t +: 3])
                         && rob_nonempty[t] && head_ready[t];
    end
endmodule

// File: rtl/arb_rotate.sv
module arb_rotate #(
    parameter int NUM_THR = 4,
    parameter int ID_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] elig,
    input  logic               take,
    output logic               pick_valid,
    output logic [ID_W-1:0]    pick_id
);
    typedef struct packed {
        logic [NUM_THR-1:0][ID_W-1:0] order;
    } rot_st_t;

    rot_st_t st_d, st_q;

    always_comb begin
        int hit_pos;
        logic hit;
        hit     = 1'b0;
        hit_pos = 0;
        for (int p = 0; p < NUM_THR; p++) begin
            if (!hit && elig[st_q.order[p]]) begin
                hit     = 1'b1;
                hit_pos = p;
            end
        end
        pick_valid = hit;
        pick_id    = hit ? st_q.order[hit_pos] : '0;

        st_d = st_q;
        if (take && hit) begin
            for (int p = 0; p < NUM_THR - 1; p++) begin
                if (p >= hit_pos) st_d.order[p] = st_q.order[p+1];
            end
            st_d.order[NUM_THR-1] = st_q.order[hit_pos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_THR; p++) st_q.order[p] <= ID_W'(p);
        end else begin
            st_q <= st_d;
        end
    end

    // order list stays a permutation of thread ids
    logic [NUM_THR-1:0] seen_ids;
    always_comb begin
        seen_ids = '0;
        for (int p = 0; p < NUM_THR; p++) seen_ids[st_q.order[p]] = 1'b1;
    end

    always @(posedge clk) begin
        if (rst_n) a_r4_order_is_perm: assert ($countones(seen_ids) == NUM_THR);
    end

    a_r3_pick_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> elig[pick_id]);

    a_r4_granted_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pick_valid) |=> (st_q.order[NUM_THR-1] == $past(pick_id)));

    a_r5_order_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && pick_valid) |=> $stable(st_q.order));
endmodule

// File: rtl/arb_oldest.sv
module arb_oldest #(
    parameter int NUM_THR = 4,
    parameter int SEQ_W   = 8,
    parameter int ID_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_THR-1:0]       elig,
    input  logic [SEQ_W*NUM_THR-1:0] head_seq,
    output logic                     pick_valid,
    output logic [ID_W-1:0]          pick_id
);
    logic [SEQ_W-1:0] seq_arr [NUM_THR];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_unpack
        assign seq_arr[t] = head_seq[SEQ_W*t +: SEQ_W];
    end

    always_comb begin
        logic [SEQ_W-1:0] best_seq;
        best_seq   = '0;
        pick_valid = 1'b0;
        pick_id    = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (elig[t] && (!pick_valid || seq_arr[t] < best_seq)) begin
                pick_valid = 1'b1;
                pick_id    = ID_W'(t);
                best_seq   = seq_arr[t];
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && pick_valid) begin
            for (int t = 0; t < NUM_THR; t++) begin
                if (elig[t]) begin
                    a_r7_none_older: assert (seq_arr[pick_id] <= seq_arr[t]);
                    a_r8_tie_low_id: assert (seq_arr[t] != seq_arr[pick_id]
                                             || t >= int'(pick_id));
                end
            end
        end
    end
endmodule

// File: rtl/smt_commit_arb.sv
module smt_commit_arb #(
    parameter int NUM_THR = 4,
    parameter int SEQ_W   = 8,
    localparam int ID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               policy,
    input  logic [3*NUM_THR-1:0]     thr_state,
    input  logic [NUM_THR-1:0]       rob_nonempty,
    input  logic [NUM_THR-1:0]       head_ready,
    input  logic [SEQ_W*NUM_THR-1:0] head_seq,
    input  logic                     grant_take,
    output logic                     grant_valid,
    output logic [ID_W-1:0]          grant_id
);
    import smt_arb_pkg::*;

    if (NUM_THR == 1) begin : g_single
        assign grant_valid = state_can_retire(thr_state[2:0]);
        assign grant_id    = '0;

        a_r10_single_status: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid == (thr_state[2:0] <= 3'd2));
    end else begin : g_multi
        logic [NUM_THR-1:0] elig;
        logic               rot_valid, old_valid;
        logic [ID_W-1:0]    rot_id, old_id;
        logic               use_rot;

        assign use_rot = (policy == POL_ROTATE);

        arb_elig #(.NUM_THR(NUM_THR)) i_elig (
            .thr_state    (thr_state),
            .rob_nonempty (rob_nonempty),
            .head_ready   (head_ready),
            .elig         (elig)
        );

        arb_rotate #(.NUM_THR(NUM_THR), .ID_W(ID_W)) i_rotate (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig),
            .take       (grant_take && use_rot),
            .pick_valid (rot_valid),
            .pick_id    (rot_id)
        );

        arb_oldest #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .ID_W(ID_W)) i_oldest (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig),
            .head_seq   (head_seq),
            .pick_valid (old_valid),
            .pick_id    (old_id)
        );

        assign grant_valid = use_rot ? rot_valid : old_valid;
        assign grant_id    = use_rot ? rot_id    : old_id;

        a_r1_grant_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |-> (thr_state[3*grant_id +: 3] <= 3'd2
                             && rob_nonempty[grant_id] && head_ready[grant_id]));

        a_r2_none_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (((rob_nonempty & head_ready) == '0) |-> (!grant_valid && grant_id == '0)));
    end
endmodule

// File: tb/test_smt_commit_arb.sv
module test_smt_commit_arb;
    localparam int N  = 4;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    policy = '0;
    logic [3*N-1:0] thr_state = '0;
    logic [N-1:0]  rob_nonempty = '0;
    logic [N-1:0]  head_ready = '0;
    logic [SW*N-1:0] head_seq = '0;
    logic          grant_take = 1'b0;
    logic          grant_valid;
    logic [1:0]    grant_id;

    logic [1:0]    s_policy = '0;
    logic [2:0]    s_state = '0;
    logic          s_ne = 1'b0, s_rd = 1'b0;
    logic [SW-1:0] s_seq = '0;
    logic          s_valid;
    logic [0:0]    s_id;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;
    int mdl [N];

    always #10 clk = ~clk;

    smt_commit_arb #(.NUM_THR(N), .SEQ_W(SW)) i_smt_commit_arb (
        .clk(clk), .rst_n(rst_n), .policy(policy), .thr_state(thr_state),
        .rob_nonempty(rob_nonempty), .head_ready(head_ready), .head_seq(head_seq),
        .grant_take(grant_take), .grant_valid(grant_valid), .grant_id(grant_id)
    );

    smt_commit_arb #(.NUM_THR(1), .SEQ_W(SW)) i_smt_commit_arb_single (
        .clk(clk), .rst_n(rst_n), .policy(s_policy), .thr_state(s_state),
        .rob_nonempty(s_ne), .head_ready(s_rd), .head_seq(s_seq),
        .grant_take(1'b1), .grant_valid(s_valid), .grant_id(s_id)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit el [N];
        bit last_rot_take;
        bit last_rot_stall;
        for (int t = 0; t < N; t++) mdl[t] = t;
        last_rot_take = 0;
        last_rot_stall = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: fresh order puts thread 0 first
        @(negedge clk);
        policy = 2'd0; thr_state = '0; rob_nonempty = '1; head_ready = '1;
        #2;
        check(grant_valid && grant_id == 2'd0, "R6", int'(grant_id), 0);

        for (int i = 0; i < 800; i++) begin
            int pol, exp_id, best, tie;
            bit exp_v;
            string req;
            @(negedge clk);
            pol = (i / 40) % 4;
            policy = 2'(pol);
            for (int t = 0; t < N; t++) begin
                thr_state[3*t +: 3]  = 3'((i * 7 + t * 3 + i / 11) % 5);
                rob_nonempty[t]      = ((i * 13 + t * 5) % 7) != 0;
                head_ready[t]        = ((i * 11 + t * 7) % 5) != 0;
                head_seq[SW*t +: SW] = SW'((i * 29 + t * 41) % 12);
                el[t] = (((i * 7 + t * 3 + i / 11) % 5) <= 2) && rob_nonempty[t] && head_ready[t];
            end
            grant_take = (i % 4) != 3;
            #2;
            exp_v = 0; exp_id = 0; tie = 0; best = 0;
            if (pol == 0) begin
                for (int p = 0; p < N; p++)
                    if (!exp_v && el[mdl[p]]) begin exp_v = 1; exp_id = mdl[p]; end
                req = last_rot_take ? "R4" : (last_rot_stall ? "R5" : "R3");
            end else begin
                for (int t = 0; t < N; t++)
                    if (el[t]) begin
                        if (!exp_v || int'(head_seq[SW*t +: SW]) < best) begin
                            exp_v = 1; exp_id = t; best = int'(head_seq[SW*t +: SW]);
                        end else if (int'(head_seq[SW*t +: SW]) == best) tie = 1;
                    end
                req = (pol >= 2) ? "R9" : (tie ? "R8" : "R7");
            end
            if (!exp_v) req = "R2";
            check(grant_valid == exp_v, req, int'(grant_valid), int'(exp_v));
            check(grant_id == 2'(exp_id), (exp_v ? req : "R1"), int'(grant_id), exp_id);

            last_rot_take  = (pol == 0) && grant_take && exp_v;
            last_rot_stall = (pol == 0) && !last_rot_take;
            if (last_rot_take) begin
                int pos;
                pos = 0;
                for (int p = 0; p < N; p++) if (mdl[p] == exp_id) pos = p;
                for (int p = 0; p < N - 1; p++) if (p >= pos) mdl[p] = mdl[p+1];
                mdl[N-1] = exp_id;
            end
        end

        // R10: single-thread bypass swept over every input combination
        for (int st = 0; st < 5; st++)
            for (int k = 0; k < 16; k++) begin
                bit ev;
                @(negedge clk);
                s_state = 3'(st);
                s_ne = k[0]; s_rd = k[1]; s_policy = 2'(k >> 2);
                s_seq = SW'(k * 17 + st);
                #2;
                ev = st <= 2;
                check(s_valid == ev && s_id == 1'b0, "R10", int'(s_valid), int'(ev));
            end

        @(negedge clk);
        grant_take = 1'b0;
        done = 1;
        summary();
        $finish;
    end
endmodule